// File: doc/BRIEF.md
# PWM Controller Register and Interrupt Front End

This block is the shared register file of a four-channel PWM controller. It sits on a plain 32-bit memory-mapped bus that has an address, a write strobe, a read strobe, write data and registered read data. It holds the per-channel run enables and the interrupt masks. Each of these is changed only through a pair of write-only set and clear registers, so that software never has to do a read-modify-write. It also holds the latched end-of-period events from the channels and drives one combined interrupt line.

Accesses that fall into the per-channel register windows are passed on to the channel blocks. The block gives one write strobe and one read strobe per channel, the offset inside the window and the write data. It then returns the read data of the selected channel. The counters and the waveform generation live in those channel blocks and are not part of this one.

Top module: `pwm_hub_regs`

## Requirements
- R1: After reset, every output is zero: chan_en, irq, mode_cfg, bus_rdata and all window strobes. Every internal register is also zero.
- R2: A write to offset 0x04 sets chan_en[n] for each 1 in bit n of the write data, and leaves every other bit unchanged. Several channels set by the same write all turn on in the same clock cycle.
- R3: A write to offset 0x08 clears chan_en[n] for each 1 in bit n of the write data, and leaves every other bit unchanged.
- R4: A read of offset 0x0C returns chan_en in bits [NCH-1:0], with zeros above.
- R5: A write to offset 0x10 sets mask bit n for each 1 in bit n. A write to offset 0x14 clears mask bit n for each 1 in bit n. A read of offset 0x18 returns the mask, with 1 meaning the interrupt is enabled.
- R6: A 1 on period_end[n] sets pending bit n. A read of offset 0x1C returns the pending bits and clears them. An event that arrives in the same cycle as that read stays pending.
- R7: irq is 1 exactly when some pending bit and its mask bit are both 1. irq follows the registers in the cycle after they change.
- R8: Writing 0xFFFFFFFF to 0x08 stops every channel. Writing 0xFFFFFFFF to 0x14 masks every interrupt.
- R9: An address 0x200 + 0x20·n + k, with n < NCH and k < 0x20, selects channel n. win_wr and win_rd then follow bus_wr and bus_rd on bit n only, in the same cycle. win_offs equals k, win_wdata equals bus_wdata, and a read returns word n of win_rdata.
- R10: Reads of any other offset return zero. This includes the write-only offsets 0x04, 0x08, 0x10 and 0x14. Writes to unmapped or read-only offsets change nothing.
- R11: bus_rdata takes the read value on the clock edge that samples bus_rd. It holds that value until the next read.
- R12: Offset 0x00 is a 32-bit read/write mode register, and its value drives mode_cfg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW (12) | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data |
| mode_cfg | output | DW (32) | Mode register contents |
| chan_en | output | NCH (4) | Channel run enables |
| period_end | input | NCH (4) | End-of-period pulses from the channels |
| irq | output | 1 | Combined interrupt |
| win_wr | output | NCH (4) | Per-channel window write strobe |
| win_rd | output | NCH (4) | Per-channel window read strobe |
| win_offs | output | 5 | Offset inside the window |
| win_wdata | output | DW (32) | Write data to the channel |
| win_rdata | input | NCH·DW (128) | Read data from the channels, word n from channel n |

## Verification
A wrong enable or mask bit shows on chan_en or irq one cycle after the write that caused it. A pending bit that is lost or left behind by a read shows on irq in the following cycle, and on bus_rdata at the next read of 0x1C. A decode fault shows in the same cycle on the window strobes, or one cycle later as a non-zero value where a zero read is expected. The reference model is compared against every output on every clock, so each of these faults is caught within one or two cycles of the access that exposes it.

// File: rtl/pwm_hub_pkg.sv
package pwm_hub_pkg;

  localparam int unsigned OFF_MODE   = 32'h00;
  localparam int unsigned OFF_EN_SET = 32'h04;
  localparam int unsigned OFF_EN_CLR = 32'h08;
  localparam int unsigned OFF_EN_STA = 32'h0C;
  localparam int unsigned OFF_IE_SET = 32'h10;
  localparam int unsigned OFF_IE_CLR = 32'h14;
  localparam int unsigned OFF_IE_STA = 32'h18;
  localparam int unsigned OFF_PEND   = 32'h1C;
  localparam int unsigned WIN_BASE   = 32'h200;
  localparam int unsigned WIN_STRIDE = 32'h20;

  typedef struct packed {
    logic mode;
    logic en_set;
    logic en_clr;
    logic en_sta;
    logic ie_set;
    logic ie_clr;
    logic ie_sta;
    logic pend;
  } reg_hit_t;

  // true when the address falls inside any channel window
  function automatic logic in_window(input logic [31:0] a, input int unsigned nch);
    return (a >= WIN_BASE) && (a < WIN_BASE + nch * WIN_STRIDE);
  endfunction

  // channel index of an address already known to be inside a window
  function automatic int unsigned window_of(input logic [31:0] a);
    return (a - WIN_BASE) / WIN_STRIDE;
  endfunction

endpackage

// File: rtl/pwm_hub_decode.sv
module pwm_hub_decode
  import pwm_hub_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 12
) (
  input  logic [AW-1:0]  addr,
  output reg_hit_t       hit,
  output logic [NCH-1:0] win_hit,
  output logic           rd_none
);

  logic [31:0] a32;
  assign a32 = 32'(addr);

  always_comb begin
    hit.mode   = (a32 == OFF_MODE);
    hit.en_set = (a32 == OFF_EN_SET);
    hit.en_clr = (a32 == OFF_EN_CLR);
    hit.en_sta = (a32 == OFF_EN_STA);
    hit.ie_set = (a32 == OFF_IE_SET);
    hit.ie_clr = (a32 == OFF_IE_CLR);
    hit.ie_sta = (a32 == OFF_IE_STA);
    hit.pend   = (a32 == OFF_PEND);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_win
    assign win_hit[i] = in_window(a32, NCH) && (window_of(a32) == 32'(i));
  end

  assign rd_none = !(hit.mode || hit.en_sta || hit.ie_sta || hit.pend || (|win_hit));

  always_comb begin
    AST_WIN_HIT_ONEHOT: assert ($onehot0(win_hit)); // R9
  end

endmodule

// File: rtl/pwm_hub_setclr.sv
module pwm_hub_setclr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_v,
  input  logic [W-1:0] clr_v,
  output logic [W-1:0] state
);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= '0;
    else        state <= (state | set_v) & ~clr_v;
  end

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v != '0 && clr_v == '0) |=> ((state & $past(set_v)) == $past(set_v))); // R2
  AST_CLR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_v != '0) |=> ((state & $past(clr_v)) == '0)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v == '0 && clr_v == '0) |=> $stable(state)); // R2

endmodule

// File: rtl/pwm_hub_irq.sv
module pwm_hub_irq #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ev,
  input  logic           rd_clr,
  input  logic [NCH-1:0] mask,
  output logic [NCH-1:0] pend,
  output logic           irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (rd_clr ? '0 : pend) | ev;
  end

  assign irq = |(pend & mask);

  AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((pend & $past(ev)) == $past(ev))); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && ev == '0) |=> (pend == '0)); // R6
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R7

endmodule

// File: rtl/pwm_hub_regs.sv
module pwm_hub_regs
  import pwm_hub_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 12,
  parameter int DW  = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [AW-1:0]                     bus_addr,
  input  logic                              bus_wr,
  input  logic                              bus_rd,
  input  logic [DW-1:0]                     bus_wdata,
  output logic [DW-1:0]                     bus_rdata,
  output logic [DW-1:0]                     mode_cfg,
  output logic [NCH-1:0]                    chan_en,
  input  logic [NCH-1:0]                    period_end,
  output logic                              irq,
  output logic [NCH-1:0]                    win_wr,
  output logic [NCH-1:0]                    win_rd,
  output logic [$clog2(WIN_STRIDE)-1:0]     win_offs,
  output logic [DW-1:0]                     win_wdata,
  input  logic [NCH*DW-1:0]                 win_rdata
);

  localparam int OFFS_W = $clog2(WIN_STRIDE);

  reg_hit_t       hit;
  logic [NCH-1:0] win_hit;
  logic           rd_none;
  logic [NCH-1:0] en_set, en_clr, ie_set, ie_clr;
  logic [NCH-1:0] ie_mask, pend;
  logic           pend_rd;
  logic [DW-1:0]  rd_val;
  logic [DW-1:0]  mode_q;

  pwm_hub_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .addr(bus_addr), .hit(hit), .win_hit(win_hit), .rd_none(rd_none)
  );

  assign en_set = (bus_wr && hit.en_set) ? bus_wdata[NCH-1:0] : '0;
  assign en_clr = (bus_wr && hit.en_clr) ? bus_wdata[NCH-1:0] : '0;
  assign ie_set = (bus_wr && hit.ie_set) ? bus_wdata[NCH-1:0] : '0;
  assign ie_clr = (bus_wr && hit.ie_clr) ? bus_wdata[NCH-1:0] : '0;

  pwm_hub_setclr #(.W(NCH)) u_en (
    .clk(clk), .rst_n(rst_n), .set_v(en_set), .clr_v(en_clr), .state(chan_en)
  );

  pwm_hub_setclr #(.W(NCH)) u_ie (
    .clk(clk), .rst_n(rst_n), .set_v(ie_set), .clr_v(ie_clr), .state(ie_mask)
  );

  assign pend_rd = bus_rd && hit.pend;

  pwm_hub_irq #(.NCH(NCH)) u_irq (
    .clk(clk), .rst_n(rst_n), .ev(period_end), .rd_clr(pend_rd),
    .mask(ie_mask), .pend(pend), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                  mode_q <= '0;
    else if (bus_wr && hit.mode) mode_q <= bus_wdata;
  end
  assign mode_cfg = mode_q;

  // channel window forwarding
  assign win_wr    = bus_wr ? win_hit : '0;
  assign win_rd    = bus_rd ? win_hit : '0;
  assign win_offs  = bus_addr[OFFS_W-1:0];
  assign win_wdata = bus_wdata;

  always_comb begin
    rd_val = '0;
    if (hit.mode)   rd_val = mode_q;
    if (hit.en_sta) rd_val = DW'(chan_en);
    if (hit.ie_sta) rd_val = DW'(ie_mask);
    if (hit.pend)   rd_val = DW'(pend);
    for (int i = 0; i < NCH; i++) begin
      if (win_hit[i]) rd_val = win_rdata[i*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && rd_none) |=> (bus_rdata == '0)); // R10
  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit.en_sta) |=> (bus_rdata == DW'($past(chan_en)))); // R4
  AST_PEND_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_rd) |=> (bus_rdata == DW'($past(pend)))); // R6
  AST_WIN_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_wr)); // R9
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd) |=> $stable(bus_rdata)); // R11

endmodule

// File: tb/pwm_hub_regs_test.sv
module pwm_hub_regs_test;

  localparam int NCH = 4;
  localparam int AW  = 12;
  localparam int DW  = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [AW-1:0]     bus_addr = '0;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [DW-1:0]     bus_wdata = '0;
  logic [DW-1:0]     bus_rdata, mode_cfg, win_wdata;
  logic [NCH-1:0]    chan_en, win_wr, win_rd;
  logic [NCH-1:0]    period_end = '0;
  logic              irq;
  logic [4:0]        win_offs;
  logic [NCH*DW-1:0] win_rdata;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_hub_regs #(.NCH(NCH), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_cfg(mode_cfg), .chan_en(chan_en),
    .period_end(period_end), .irq(irq), .win_wr(win_wr), .win_rd(win_rd),
    .win_offs(win_offs), .win_wdata(win_wdata), .win_rdata(win_rdata)
  );

  // channel model: each channel answers a recognisable word
  function automatic logic [31:0] chan_word(input int n, input int k);
    return 32'h5A00_0000 | (32'(n) << 16) | 32'(k);
  endfunction

  always_comb begin
    for (int n = 0; n < NCH; n++) win_rdata[n*DW +: DW] = chan_word(n, int'(win_offs));
  end

  // reference model state
  logic [31:0]    m_mode = 0, m_rdata = 0;
  logic [NCH-1:0] m_en = 0, m_mask = 0, m_pend = 0;
  string          m_rtag = "R1";

  function automatic bit is_win(input int a);
    return a >= 'h200 && a < 'h200 + NCH * 'h20;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_rdata = 0; m_en = 0; m_mask = 0; m_pend = 0;
    end else begin
      int a;
      logic [NCH-1:0] w;
      a = int'(bus_addr);
      w = bus_wdata[NCH-1:0];
      if (bus_rd) begin
        case (a)
          'h00: begin m_rdata = m_mode; m_rtag = "R12"; end
          'h0C: begin m_rdata = 32'(m_en); m_rtag = "R4"; end
          'h18: begin m_rdata = 32'(m_mask); m_rtag = "R5"; end
          'h1C: begin m_rdata = 32'(m_pend); m_rtag = "R6"; end
          default: begin
            if (is_win(a)) begin m_rdata = chan_word((a - 'h200) / 'h20, a % 'h20); m_rtag = "R9"; end
            else begin m_rdata = 0; m_rtag = "R10"; end
          end
        endcase
        if (a == 'h1C) m_pend = 0;
      end
      m_pend = m_pend | period_end;
      if (bus_wr) begin
        case (a)
          'h00: m_mode = bus_wdata;
          'h04: m_en = m_en | w;
          'h08: m_en = m_en & ~w;
          'h10: m_mask = m_mask | w;
          'h14: m_mask = m_mask & ~w;
          default: ;
        endcase
      end
    end
  end

  task automatic cmp_regs();
    chk(m_rtag, bus_rdata, m_rdata);            // R11 timing
    chk("R2", 32'(chan_en), 32'(m_en));
    chk("R7", 32'(irq), 32'(|(m_pend & m_mask)));
    chk("R12", mode_cfg, m_mode);
  endtask

  task automatic cmp_win();
    int a;
    logic [NCH-1:0] sel;
    a = int'(bus_addr);
    sel = is_win(a) ? NCH'(1 << ((a - 'h200) / 'h20)) : '0;
    chk("R9", 32'(win_wr), 32'(bus_wr ? sel : '0));
    chk("R9", 32'(win_rd), 32'(bus_rd ? sel : '0));
    chk("R9", 32'(win_offs), 32'(a % 32));
    chk("R9", win_wdata, bus_wdata);
  endtask

  task automatic step(input int a, input bit wr, input bit rd, input logic [31:0] wd,
                      input logic [NCH-1:0] ev);
    @(negedge clk);
    cmp_regs();
    bus_addr = AW'(a); bus_wr = wr; bus_rd = rd; bus_wdata = wd; period_end = ev;
    #1 cmp_win();
  endtask

  task automatic wr(input int a, input logic [31:0] d); step(a, 1, 0, d, '0); endtask
  task automatic rd(input int a); step(a, 0, 1, 0, '0); endtask
  task automatic settle(); step(0, 0, 0, 0, '0); endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", bus_rdata, 0); chk("R1", mode_cfg, 0); chk("R1", 32'(chan_en), 0);
    chk("R1", 32'(irq), 0); chk("R1", 32'(win_wr | win_rd), 0);
    rst_n = 1'b1;

    // R12 mode register
    wr('h00, 32'hDEAD_BEEF); rd('h00); settle();
    chk("R12", bus_rdata, 32'hDEAD_BEEF);

    // R2 grouped start, then R2 zero bits keep state
    wr('h04, 32'h5); settle();
    chk("R2", 32'(chan_en), 32'h5);
    wr('h04, 32'h2); rd('h0C); settle();
    chk("R4", bus_rdata, 32'h7);
    // R3 stop one channel
    wr('h08, 32'h1); settle();
    chk("R3", 32'(chan_en), 32'h6);

    // R5 interrupt masks
    wr('h10, 32'h3); wr('h14, 32'h1); rd('h18); settle();
    chk("R5", bus_rdata, 32'h2);

    // R6 and R7: events, irq, read-clear with a colliding event
    step(0, 0, 0, 0, 4'hA); settle();
    chk("R7", 32'(irq), 1);
    step('h1C, 0, 1, 0, 4'h4); settle();
    chk("R6", bus_rdata, 32'hA);
    chk("R7", 32'(irq), 0);
    rd('h1C); settle();
    chk("R6", bus_rdata, 32'h4);
    rd('h1C); settle();
    chk("R6", bus_rdata, 32'h0);

    // R8 all ones stops and masks everything
    wr('h04, 32'hF); wr('h10, 32'hF);
    wr('h08, 32'hFFFF_FFFF); wr('h14, 32'hFFFF_FFFF); rd('h18); settle();
    chk("R8", 32'(chan_en), 0);
    chk("R8", bus_rdata, 0);

    // R9 channel windows
    wr('h224, 32'h1234_5678); rd('h200); rd('h264); rd('h27C); settle();
    chk("R9", bus_rdata, chan_word(3, 'h1C));

    // R10 unmapped and write-only offsets
    wr('h0C, 32'hF); wr('h1C, 32'hF); wr('h300, 32'hF); wr('h18, 32'hF);
    rd('h280); settle(); chk("R10", bus_rdata, 0);
    rd('h04); settle(); chk("R10", bus_rdata, 0);
    rd('h0C); settle(); chk("R10", bus_rdata, 0);
    rd('h18); settle(); chk("R10", bus_rdata, 0);

    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      int pick, addrs[12];
      addrs = '{'h00, 'h04, 'h08, 'h0C, 'h10, 'h14, 'h18, 'h1C, 'h208, 'h25C, 'h280, 'h02};
      pick = $urandom_range(0, 11);
      case ($urandom_range(0, 2))
        0: step(addrs[pick], 1, 0, $urandom, NCH'($urandom));
        1: step(addrs[pick], 0, 1, 0, NCH'($urandom));
        default: step(addrs[pick], 0, 0, 0, ($urandom_range(0, 3) == 0) ? NCH'($urandom) : '0);
      endcase
    end
    settle(); settle();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not end");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule